// File: doc/BRIEF.md
# Reset-Sampled Test Mode Controller

This block decides, once per reset, whether a serial audio-link device runs normally or enters a test mode. It does not use a dedicated mode pin. It reads the levels of the two link inputs, the frame sync and the serial data output from the controller, in the first clock cycle after the active-low link reset is released. The two-bit code chooses one of three modes: normal operation, board-test mode or internal vendor test mode. In board-test mode the block turns off the output enables of the link outputs and of the general-purpose, identity-strap and auxiliary pins, and it turns off the internal pull-ups. A board tester can then drive those nets freely.

A test mode is sticky. The mode register returns to normal only during a cold reset in which both link inputs are low at the same time. Other resets, and later release codes, leave the mode as it is. While reset is asserted, every pad enable is on and the status output reads normal. When reset is released, the stored mode takes effect again. The pad enables and status outputs feed the pad ring and the observing logic directly.

Top module: `test_mode_ctrl`

## Requirements
- R1: In the first clock cycle where `link_rst_n` is seen high after being low, the block forms the code {`link_sync`, `link_sdo`}. If the current mode is normal, it sets the mode from that code: 2'b00 gives normal (status 2'b00), 2'b01 gives board-test (status 2'b01), and 2'b10 gives vendor test (status 2'b10).
- R2: The release code 2'b11 selects normal operation, and all enables stay on.
- R3: In board-test mode, both bits of `link_oe` are 0. Bit 0 is the bit-clock output and bit 1 is the serial data return.
- R4: In board-test mode, every bit of `gpio_oe`, `id_oe` and `aux_oe` is 0.
- R5: In board-test mode, every bit of `pullup_en` is 0.
- R6: In vendor test mode, all output enables and pull-up enables are 1 and the status is 2'b10.
- R7: If a test mode is active, a reset release with any code leaves the mode unchanged.
- R8: The mode is cleared to normal only by a clock cycle during reset in which `link_sync` and `link_sdo` are both low. A reset in which this never happens keeps the stored mode.
- R9: While `link_rst_n` is low, every enable output is 1, `mode_status` is 2'b00 and `tristate_all` is 0.
- R10: Changes on `link_sync` and `link_sdo` while out of reset have no effect on the mode.
- R11: `tristate_all` is 1 exactly when the block is out of reset and in board-test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-domain clock |
| link_rst_n | input | 1 | Active-low cold reset of the link |
| link_sync | input | 1 | Frame sync level from the controller |
| link_sdo | input | 1 | Serial data output level from the controller |
| link_oe | output | NUM_LINK | Output enables: bit 0 bit clock, bit 1 serial data return |
| gpio_oe | output | NUM_GPIO | General-purpose pin output enables |
| id_oe | output | NUM_ID | Identity-strap pin output enables |
| aux_oe | output | NUM_AUX | Power-down control and digital audio output enables |
| pullup_en | output | NUM_GPIO+NUM_ID | Internal pull-up enables for the digital I/O pins |
| mode_status | output | 2 | Current effective mode |
| tristate_all | output | 1 | High while board-test mode floats the pads |

## Verification
The bench builds the block with `NUM_GPIO=3` and `NUM_AUX=3` and leaves the other widths at their defaults. With unequal group widths, a generate loop that covers the wrong range leaves a bit stuck on or off, and the comparison against an all-ones or all-zeros reference catches it. The stimulus walks through all four release codes. It includes resets whose link levels never reach 0/0, which covers the sticky behaviour, and it toggles the link inputs after release so that any change away from the release edge shows up.

// File: rtl/tm_pkg.sv
package tm_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_BOARD  = 2'b01,
        MODE_VENDOR = 2'b10
    } tm_mode_e;

    // Release code {sync, sdo} to mode; the reserved value maps to normal.
    function automatic tm_mode_e decode_strap(input logic [1:0] code);
        tm_mode_e m;
        case (code)
            2'b01:   m = MODE_BOARD;
            2'b10:   m = MODE_VENDOR;
            default: m = MODE_NORMAL;
        endcase
        return m;
    endfunction

    function automatic logic pads_float(input tm_mode_e m);
        return (m == MODE_BOARD);
    endfunction

endpackage

// File: rtl/tm_release_detect.sv
module tm_release_detect (
    input  logic       clk,
    input  logic       rst_n_i,
    input  logic       sync_i,
    input  logic       sdo_i,
    output logic       release_o,
    output logic       clean_o,
    output logic [1:0] code_o
);
    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst_n_i;
    end

    assign release_o = rst_n_i & ~rst_seen_q;
    assign clean_o   = ~rst_n_i & ~sync_i & ~sdo_i;
    assign code_o    = {sync_i, sdo_i};

endmodule

// File: rtl/tm_mode_reg.sv
module tm_mode_reg
    import tm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n_i,
    input  logic       release_i,
    input  logic       clean_i,
    input  logic [1:0] code_i,
    output tm_mode_e   mode_o
);
    tm_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (clean_i) begin
            mode_q <= MODE_NORMAL;
        end else if (release_i && (mode_q == MODE_NORMAL)) begin
            mode_q <= decode_strap(code_i);
        end
    end

    assign mode_o = mode_q;

    AST_ENTER_BOARD: assert property (@(posedge clk) disable iff (!rst_n_i)
        (release_i && mode_q == MODE_NORMAL && code_i == 2'b01) |=> (mode_q == MODE_BOARD)); // R1
    AST_RESERVED_NORMAL: assert property (@(posedge clk) disable iff (!rst_n_i)
        (release_i && mode_q == MODE_NORMAL && code_i == 2'b11) |=> (mode_q == MODE_NORMAL)); // R2
    AST_TEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n_i)
        (release_i && mode_q != MODE_NORMAL) |=> $stable(mode_q)); // R7
    AST_NO_MIDRUN_CHANGE: assert property (@(posedge clk) disable iff (!rst_n_i)
        (!release_i) |=> $stable(mode_q)); // R10

endmodule

// File: rtl/tm_pad_ctrl.sv
module tm_pad_ctrl
    import tm_pkg::*;
#(
    parameter int NUM_LINK = 2,
    parameter int NUM_GPIO = 2,
    parameter int NUM_ID   = 2,
    parameter int NUM_AUX  = 2,
    localparam int NUM_PU  = NUM_GPIO + NUM_ID
) (
    input  logic                clk,
    input  logic                rst_n_i,
    input  tm_mode_e            mode_i,
    output logic [NUM_LINK-1:0] link_oe_o,
    output logic [NUM_GPIO-1:0] gpio_oe_o,
    output logic [NUM_ID-1:0]   id_oe_o,
    output logic [NUM_AUX-1:0]  aux_oe_o,
    output logic [NUM_PU-1:0]   pu_en_o,
    output logic [1:0]          mode_o,
    output logic                tri_all_o
);
    tm_mode_e eff_mode;
    logic     drive_on;

    assign eff_mode  = rst_n_i ? mode_i : MODE_NORMAL;
    assign drive_on  = ~pads_float(eff_mode);
    assign tri_all_o = ~drive_on;
    assign mode_o    = eff_mode;

    for (genvar i = 0; i < NUM_LINK; i++) begin : g_link
        assign link_oe_o[i] = drive_on;
    end
    for (genvar i = 0; i < NUM_GPIO; i++) begin : g_gpio
        assign gpio_oe_o[i] = drive_on;
    end
    for (genvar i = 0; i < NUM_ID; i++) begin : g_id
        assign id_oe_o[i] = drive_on;
    end
    for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux
        assign aux_oe_o[i] = drive_on;
    end
    for (genvar i = 0; i < NUM_PU; i++) begin : g_pu
        assign pu_en_o[i] = drive_on;
    end

    AST_BOARD_LINK_FLOAT: assert property (@(posedge clk) disable iff (!rst_n_i)
        (mode_i == MODE_BOARD) |-> (link_oe_o == '0)); // R3
    AST_BOARD_PINS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n_i)
        (mode_i == MODE_BOARD) |-> (gpio_oe_o == '0 && id_oe_o == '0 && aux_oe_o == '0)); // R4
    AST_BOARD_PULLUP_OFF: assert property (@(posedge clk) disable iff (!rst_n_i)
        (mode_i == MODE_BOARD) |-> (pu_en_o == '0)); // R5
    AST_VENDOR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n_i)
        (mode_i == MODE_VENDOR) |-> (&link_oe_o && &pu_en_o && mode_o == 2'b10)); // R6

endmodule

// File: rtl/test_mode_ctrl.sv
module test_mode_ctrl
    import tm_pkg::*;
#(
    parameter int NUM_LINK = 2,
    parameter int NUM_GPIO = 2,
    parameter int NUM_ID   = 2,
    parameter int NUM_AUX  = 2,
    localparam int NUM_PU  = NUM_GPIO + NUM_ID
) (
    input  logic                clk,
    input  logic                link_rst_n,
    input  logic                link_sync,
    input  logic                link_sdo,
    output logic [NUM_LINK-1:0] link_oe,
    output logic [NUM_GPIO-1:0] gpio_oe,
    output logic [NUM_ID-1:0]   id_oe,
    output logic [NUM_AUX-1:0]  aux_oe,
    output logic [NUM_PU-1:0]   pullup_en,
    output logic [1:0]          mode_status,
    output logic                tristate_all
);
    logic       rel_edge;
    logic       clean_cyc;
    logic [1:0] rel_code;
    tm_mode_e   stored_mode;

    tm_release_detect u_detect (
        .clk       (clk),
        .rst_n_i   (link_rst_n),
        .sync_i    (link_sync),
        .sdo_i     (link_sdo),
        .release_o (rel_edge),
        .clean_o   (clean_cyc),
        .code_o    (rel_code)
    );

    tm_mode_reg u_mode (
        .clk       (clk),
        .rst_n_i   (link_rst_n),
        .release_i (rel_edge),
        .clean_i   (clean_cyc),
        .code_i    (rel_code),
        .mode_o    (stored_mode)
    );

    tm_pad_ctrl #(
        .NUM_LINK (NUM_LINK),
        .NUM_GPIO (NUM_GPIO),
        .NUM_ID   (NUM_ID),
        .NUM_AUX  (NUM_AUX)
    ) u_pads (
        .clk       (clk),
        .rst_n_i   (link_rst_n),
        .mode_i    (stored_mode),
        .link_oe_o (link_oe),
        .gpio_oe_o (gpio_oe),
        .id_oe_o   (id_oe),
        .aux_oe_o  (aux_oe),
        .pu_en_o   (pullup_en),
        .mode_o    (mode_status),
        .tri_all_o (tristate_all)
    );

    always_ff @(posedge clk) begin
        if (!link_rst_n) begin
            AST_RESET_PADS_ON: assert (&link_oe && &gpio_oe && &id_oe && &aux_oe
                                       && &pullup_en && mode_status == 2'b00 && !tristate_all); // R9
        end
    end

    AST_TRISTATE_FLAG: assert property (@(posedge clk) disable iff (!link_rst_n)
        tristate_all == (mode_status == 2'b01)); // R11

endmodule

// File: tb/test_mode_ctrl_tb.sv
module test_mode_ctrl_tb;
    localparam int NL = 2;
    localparam int NG = 3;
    localparam int NI = 2;
    localparam int NA = 3;
    localparam int NP = NG + NI;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_in = 1'b0;
    logic d_in = 1'b0;
    logic [NL-1:0] link_oe;
    logic [NG-1:0] gpio_oe;
    logic [NI-1:0] id_oe;
    logic [NA-1:0] aux_oe;
    logic [NP-1:0] pullup_en;
    logic [1:0]    mode_status;
    logic          tristate_all;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int mdl = 0;
    logic prev_rst = 1'b0;
    string phase = "R9";
    bit done = 1'b0;

    always #4 clk = ~clk;

    test_mode_ctrl #(.NUM_LINK(NL), .NUM_GPIO(NG), .NUM_ID(NI), .NUM_AUX(NA)) u_dut (
        .clk(clk), .link_rst_n(rst_n), .link_sync(s_in), .link_sdo(d_in),
        .link_oe(link_oe), .gpio_oe(gpio_oe), .id_oe(id_oe), .aux_oe(aux_oe),
        .pullup_en(pullup_en), .mode_status(mode_status), .tristate_all(tristate_all)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s (%s) actual=%0d expected=%0d t=%0t", tag, phase, act, exp, $time);
        end
    endtask

    // Behavioural reference: updates on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            if (!s_in && !d_in) mdl = 0;
        end else if (!prev_rst && mdl == 0) begin
            case ({s_in, d_in})
                2'b01:   mdl = 1;
                2'b10:   mdl = 2;
                default: mdl = 0;
            endcase
        end
        prev_rst = rst_n;
    end

    // Full output comparison away from the active edge.
    always @(negedge clk) begin
        int em;
        bit flt;
        em  = rst_n ? mdl : 0;
        flt = (em == 1);
        chk(int'(mode_status), em, "R1");
        chk(int'(link_oe),   flt ? 0 : (1 << NL) - 1, "R3");
        chk(int'(gpio_oe),   flt ? 0 : (1 << NG) - 1, "R4");
        chk(int'(id_oe),     flt ? 0 : (1 << NI) - 1, "R4");
        chk(int'(aux_oe),    flt ? 0 : (1 << NA) - 1, "R4");
        chk(int'(pullup_en), flt ? 0 : (1 << NP) - 1, "R5");
        chk(int'(tristate_all), flt ? 1 : 0, "R11");
    end

    task automatic drive(input logic r, input logic s, input logic d, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            rst_n = r; s_in = s; d_in = d;
        end
    endtask

    task automatic cold(input logic ds, input logic dd, input logic rs, input logic rd);
        drive(1'b0, ds, dd, 3);
        drive(1'b1, rs, rd, 1);
        drive(1'b1, 1'b0, 1'b0, 3);
    endtask

    task automatic expect_mode(input int e, input string tag);
        chk(int'(mode_status), e, tag);
    endtask

    initial begin
        @(negedge clk);
        #1;
        phase = "R9";
        chk(int'(mode_status), 0, "R9");
        chk(int'(pullup_en), (1 << NP) - 1, "R9");

        phase = "R1"; cold(0, 0, 0, 0); expect_mode(0, "R1");
        phase = "R1"; cold(0, 0, 0, 1); expect_mode(1, "R1");
        chk(int'(link_oe), 0, "R3");
        phase = "R10";
        drive(1'b1, 1'b1, 1'b0, 2);
        drive(1'b1, 1'b1, 1'b1, 2);
        drive(1'b1, 1'b0, 1'b0, 2);
        expect_mode(1, "R10");
        phase = "R8";
        drive(1'b0, 1'b0, 1'b1, 2);
        chk(int'(tristate_all), 0, "R9");
        drive(1'b1, 1'b0, 1'b0, 1);
        drive(1'b1, 1'b0, 1'b0, 2);
        expect_mode(1, "R8");
        phase = "R6"; cold(0, 0, 1, 0); expect_mode(2, "R6");
        chk(int'(aux_oe), (1 << NA) - 1, "R6");
        phase = "R7"; cold(1, 0, 0, 1); expect_mode(2, "R7");
        phase = "R2"; cold(0, 0, 1, 1); expect_mode(0, "R2");
        chk(int'(gpio_oe), (1 << NG) - 1, "R2");
        phase = "R7"; cold(0, 0, 0, 1); cold(1, 1, 1, 0); expect_mode(1, "R7");
        phase = "R8"; cold(0, 0, 0, 0); expect_mode(0, "R8");
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
        end
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule